// File: doc/BRIEF.md
# Linked-List Buffer Mover

This block copies data between system memory and a peripheral's data FIFO. The buffers are described by a linked list of descriptors held in memory. Software writes the address of the first descriptor, picks a direction and sets a run bit. The engine then reads each descriptor over a single memory port and moves the words of the described buffer. When a descriptor is done, the engine follows that descriptor's link to the next one. It stops after a descriptor that carries the last-in-chain flag.

On every stop, whether the chain succeeded or failed, the engine clears the run bit and records a four-bit outcome code. It also sets an interrupt status flag, which drives the interrupt line when the interrupt is enabled. Each failure has its own code: a peripheral that ends early, a FIFO that runs dry or fills up, a bad descriptor, and a failed data access.

Top module: `chain_dma`

## Requirements
- R1: After reset every register reads zero, `irq` is low, and no memory, push or pop strobe is active.
- R2: Register index 0 is the global control. Bit 0 is the engine enable and reads back as written. Writing bit 8 as 1 is a soft reset: it returns every register to its reset value, ignores the other bits of that write, and bit 8 always reads 0.
- R3: Register index 4 is the channel control, with bit 7 as run and bit 22 as direction. Writing bit 7 as 1 while enable is set starts fetching at the address held in register index 3. The three descriptor words are read at that address plus 0, 4 and 8. While enable is clear, the same write leaves run at 0 and issues no memory request.
- R4: A descriptor is four 32-bit words: flags, buffer address, link address and a reserved word. In the flags word, bits 15:0 are the byte count, bit 30 must be 1 and bit 31 marks the last descriptor. The reserved word at offset 12 is never read.
- R5: With direction 0 (memory to peripheral), the engine reads ceil(count/4) words from the buffer at increasing addresses, 4 bytes apart, and pushes them into the FIFO in that order. A count of 0 moves nothing.
- R6: With direction 1 (peripheral to memory), the engine pops ceil(count/4) words from the FIFO and writes them to the buffer at increasing addresses, 4 bytes apart.
- R7: After a descriptor whose bit 31 is clear, the next descriptor is fetched from its link address. After the last descriptor, run clears, channel control bits 3:0 read 0xF and the status flag sets.
- R8: If a descriptor's bit 30 is 0, or if any descriptor word read returns an error, the engine stops with code 3.
- R9: A memory error on a buffer read or write stops the engine with code 4.
- R10: On direction 1, an empty FIFO when a word is needed stops the engine with code 1 and no pop. On direction 0, a full FIFO when a word must be pushed stops it with code 2 and no push.
- R11: If `periph_end` is high while words remain, the engine stops with code 5 before moving the next word. If no words remain, `periph_end` has no effect.
- R12: The status flag is bit 0 of register index 2 and is cleared only by writing 1 to it. Register index 1, bit 0, is the interrupt enable. `irq` is high exactly when both bits are 1.
- R13: Writes to the channel control while run is 1 are ignored. Bits 3:0 cannot be written, and they read 0 from the start of each run until it stops.
- R14: A memory request keeps its address and write strobe stable until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| cfg_we | input | 1 | register write strobe |
| cfg_addr | input | 3 | register word index |
| cfg_wdata | input | 32 | register write data |
| cfg_rdata | output | 32 | register read data (combinational) |
| mem_req | output | 1 | memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | byte address |
| mem_wdata | output | DATA_W | memory write data |
| mem_ack | input | 1 | request completed this cycle |
| mem_rdata | input | DATA_W | read data, valid with ack |
| mem_err | input | 1 | access failed, valid with ack |
| fifo_push | output | 1 | push a word into the peripheral FIFO |
| fifo_wdata | output | DATA_W | pushed word |
| fifo_full | input | 1 | FIFO cannot accept a word |
| fifo_pop | output | 1 | pop a word from the peripheral FIFO |
| fifo_rdata | input | DATA_W | word at the FIFO head |
| fifo_empty | input | 1 | FIFO has no word |
| periph_end | input | 1 | peripheral has finished its data |
| irq | output | 1 | interrupt request |

## Verification
A wrong word count or a wrong buffer pointer shows at the ports within a few cycles. It appears as an extra or missing push or memory write, or as a word at the wrong address, and the bench compares these against the FIFO log and the memory image. A wrong chain pointer shows at the first memory request after a descriptor ends, because the fetch goes to the wrong address. A mishandled stop shows in the outcome code and in the run bit on the next register read. A lost status update shows on `irq` in the cycle after the stop.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_FETCH, ST_BEAT, ST_MEMRD, ST_FIFOWR, ST_MEMWR
   } dma_state_t;

   localparam logic [3:0] EV_NONE  = 4'h0;
   localparam logic [3:0] EV_UNDER = 4'h1;
   localparam logic [3:0] EV_OVER  = 4'h2;
   localparam logic [3:0] EV_DESC  = 4'h3;
   localparam logic [3:0] EV_DATA  = 4'h4;
   localparam logic [3:0] EV_EARLY = 4'h5;
   localparam logic [3:0] EV_OK    = 4'hF;

   localparam logic [2:0] RG_GCTL = 3'd0;
   localparam logic [2:0] RG_IEN  = 3'd1;
   localparam logic [2:0] RG_ISTS = 3'd2;
   localparam logic [2:0] RG_DPTR = 3'd3;
   localparam logic [2:0] RG_CCTL = 3'd4;

   localparam int GC_EN   = 0;
   localparam int GC_SRST = 8;
   localparam int CC_RUN  = 7;
   localparam int CC_DIR  = 22;
   localparam int DF_FMT  = 30;
   localparam int DF_LAST = 31;
endpackage

// File: rtl/chain_dma_len.sv
module chain_dma_len #(
   parameter int CNT_W    = 16,
   parameter int SHIFT    = 2,
   parameter bit ROUND_UP = 1'b1
) (
   input  logic [CNT_W-1:0]     bytes_i,
   output logic [CNT_W-SHIFT:0] words_o
);
   if (SHIFT < 1 || SHIFT >= CNT_W) begin : g_bad_shift
      $error("chain_dma_len: SHIFT out of range");
   end

   if (ROUND_UP) begin : g_ceil
      logic [CNT_W:0] sum;
      assign sum     = {1'b0, bytes_i} + (CNT_W+1)'((1 << SHIFT) - 1);
      assign words_o = sum[CNT_W:SHIFT];
   end else begin : g_floor
      assign words_o = {1'b0, bytes_i[CNT_W-1:SHIFT]};
   end
endmodule

// File: rtl/chain_dma_regs.sv
module chain_dma_regs
   import chain_dma_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [2:0]    cfg_addr,
   input  logic [31:0]   cfg_wdata,
   output logic [31:0]   cfg_rdata,
   output logic          soft_rst,
   output logic          start,
   output logic [AW-1:0] start_ptr,
   output logic          start_dir,
   output logic          run_o,
   input  logic          fin,
   input  logic [3:0]    fin_code,
   output logic          irq
);
   if (AW > 32 || AW < 8) begin : g_bad_aw
      $error("chain_dma_regs: AW must be 8..32");
   end

   logic          en_q, ien_q, ists_q, run_q, dir_q;
   logic [3:0]    evt_q;
   logic [AW-1:0] dptr_q;
   logic          hit_g, hit_ie, hit_is, hit_dp, hit_cc;

   assign hit_g  = cfg_we && (cfg_addr == RG_GCTL);
   assign hit_ie = cfg_we && (cfg_addr == RG_IEN);
   assign hit_is = cfg_we && (cfg_addr == RG_ISTS);
   assign hit_dp = cfg_we && (cfg_addr == RG_DPTR);
   assign hit_cc = cfg_we && (cfg_addr == RG_CCTL);

   assign soft_rst  = hit_g && cfg_wdata[GC_SRST];
   assign start     = hit_cc && cfg_wdata[CC_RUN] && !run_q && en_q;
   assign start_ptr = dptr_q;
   assign start_dir = cfg_wdata[CC_DIR];
   assign run_o     = run_q;
   assign irq       = ien_q && ists_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0; ien_q <= 1'b0; ists_q <= 1'b0; run_q <= 1'b0;
         dir_q <= 1'b0; evt_q <= EV_NONE; dptr_q <= '0;
      end else if (soft_rst) begin
         en_q <= 1'b0; ien_q <= 1'b0; ists_q <= 1'b0; run_q <= 1'b0;
         dir_q <= 1'b0; evt_q <= EV_NONE; dptr_q <= '0;
      end else begin
         if (hit_g)  en_q   <= cfg_wdata[GC_EN];
         if (hit_ie) ien_q  <= cfg_wdata[0];
         if (hit_dp) dptr_q <= cfg_wdata[AW-1:0];
         if (hit_cc && !run_q) begin
            dir_q <= cfg_wdata[CC_DIR];
            run_q <= cfg_wdata[CC_RUN] && en_q;
            if (start) evt_q <= EV_NONE;
         end
         if (hit_is && cfg_wdata[0]) ists_q <= 1'b0;
         if (fin) begin
            run_q  <= 1'b0;
            evt_q  <= fin_code;
            ists_q <= 1'b1;
         end
      end
   end

   always_comb begin
      cfg_rdata = '0;
      case (cfg_addr)
         RG_GCTL: cfg_rdata[GC_EN] = en_q;
         RG_IEN:  cfg_rdata[0]     = ien_q;
         RG_ISTS: cfg_rdata[0]     = ists_q;
         RG_DPTR: cfg_rdata        = 32'(dptr_q);
         RG_CCTL: cfg_rdata        = {9'b0, dir_q, 14'b0, run_q, 3'b0, evt_q};
         default: cfg_rdata        = '0;
      endcase
   end

   // R7: a stop report leaves run clear and the status flag set
   p_fin_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fin && !soft_rst) |=> (!run_q && ists_q));
endmodule

// File: rtl/chain_dma_engine.sv
module chain_dma_engine
   import chain_dma_pkg::*;
#(
   parameter int AW       = 32,
   parameter int DW       = 32,
   parameter int CNT_W    = 16,
   parameter bit ROUND_UP = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          srst,
   input  logic          start,
   input  logic [AW-1:0] start_ptr,
   input  logic          start_dir,
   output logic          busy,
   output logic          fin,
   output logic [3:0]    fin_code,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic          mem_ack,
   input  logic [DW-1:0] mem_rdata,
   input  logic          mem_err,
   output logic          fifo_push,
   output logic [DW-1:0] fifo_wdata,
   input  logic          fifo_full,
   output logic          fifo_pop,
   input  logic [DW-1:0] fifo_rdata,
   input  logic          fifo_empty,
   input  logic          periph_end
);
   localparam int BPW   = DW / 8;
   localparam int SHIFT = $clog2(BPW);
   localparam int WW    = CNT_W - SHIFT + 1;

   if (DW != 32) begin : g_bad_dw
      $error("chain_dma_engine: descriptor words need DW == 32");
   end
   if (CNT_W > 16) begin : g_bad_cnt
      $error("chain_dma_engine: byte count field is at most 16 bits");
   end

   dma_state_t    state_q, state_d;
   logic [AW-1:0] ptr_q, ptr_d, buf_q, buf_d, nxt_q, nxt_d;
   logic [1:0]    widx_q, widx_d;
   logic          last_q, last_d, dir_q, dir_d;
   logic [WW-1:0] left_q, left_d, len_words;
   logic [DW-1:0] hold_q, hold_d;

   chain_dma_len #(.CNT_W(CNT_W), .SHIFT(SHIFT), .ROUND_UP(ROUND_UP)) u_len (
      .bytes_i (mem_rdata[CNT_W-1:0]),
      .words_o (len_words)
   );

   assign busy = (state_q != ST_IDLE);

   always_comb begin
      state_d = state_q; ptr_d = ptr_q; buf_d = buf_q; nxt_d = nxt_q;
      widx_d = widx_q; last_d = last_q; dir_d = dir_q; left_d = left_q;
      hold_d = hold_q;
      mem_req = 1'b0; mem_we = 1'b0; mem_addr = buf_q; mem_wdata = hold_q;
      fifo_push = 1'b0; fifo_pop = 1'b0; fifo_wdata = hold_q;
      fin = 1'b0; fin_code = EV_NONE;
      case (state_q)
         ST_IDLE: if (start) begin
            state_d = ST_FETCH; ptr_d = start_ptr; dir_d = start_dir; widx_d = 2'd0;
         end
         ST_FETCH: begin
            mem_req  = 1'b1;
            mem_addr = ptr_q + AW'({widx_q, 2'b00});
            if (mem_ack) begin
               if (mem_err || (widx_q == 2'd0 && !mem_rdata[DF_FMT])) begin
                  fin = 1'b1; fin_code = EV_DESC; state_d = ST_IDLE;
               end else begin
                  case (widx_q)
                     2'd0: begin
                        last_d = mem_rdata[DF_LAST]; left_d = len_words; widx_d = 2'd1;
                     end
                     2'd1: begin buf_d = mem_rdata[AW-1:0]; widx_d = 2'd2; end
                     default: begin nxt_d = mem_rdata[AW-1:0]; state_d = ST_BEAT; end
                  endcase
               end
            end
         end
         ST_BEAT: begin
            if (left_q == '0) begin
               if (last_q) begin
                  fin = 1'b1; fin_code = EV_OK; state_d = ST_IDLE;
               end else begin
                  ptr_d = nxt_q; widx_d = 2'd0; state_d = ST_FETCH;
               end
            end else if (periph_end) begin
               fin = 1'b1; fin_code = EV_EARLY; state_d = ST_IDLE;
            end else if (dir_q) begin
               if (fifo_empty) begin
                  fin = 1'b1; fin_code = EV_UNDER; state_d = ST_IDLE;
               end else begin
                  fifo_pop = 1'b1; hold_d = fifo_rdata; state_d = ST_MEMWR;
               end
            end else begin
               state_d = ST_MEMRD;
            end
         end
         ST_MEMRD: begin
            mem_req = 1'b1;
            if (mem_ack) begin
               if (mem_err) begin
                  fin = 1'b1; fin_code = EV_DATA; state_d = ST_IDLE;
               end else begin
                  hold_d = mem_rdata; state_d = ST_FIFOWR;
               end
            end
         end
         ST_FIFOWR: begin
            if (fifo_full) begin
               fin = 1'b1; fin_code = EV_OVER; state_d = ST_IDLE;
            end else begin
               fifo_push = 1'b1; left_d = left_q - WW'(1);
               buf_d = buf_q + AW'(BPW); state_d = ST_BEAT;
            end
         end
         ST_MEMWR: begin
            mem_req = 1'b1; mem_we = 1'b1;
            if (mem_ack) begin
               if (mem_err) begin
                  fin = 1'b1; fin_code = EV_DATA; state_d = ST_IDLE;
               end else begin
                  left_d = left_q - WW'(1); buf_d = buf_q + AW'(BPW); state_d = ST_BEAT;
               end
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE; ptr_q <= '0; buf_q <= '0; nxt_q <= '0; widx_q <= '0;
         last_q <= 1'b0; dir_q <= 1'b0; left_q <= '0; hold_q <= '0;
      end else if (srst) begin
         state_q <= ST_IDLE; widx_q <= '0; left_q <= '0;
      end else begin
         state_q <= state_d; ptr_q <= ptr_d; buf_q <= buf_d; nxt_q <= nxt_d;
         widx_q <= widx_d; last_q <= last_d; dir_q <= dir_d; left_q <= left_d;
         hold_q <= hold_d;
      end
   end

   // R14: an unanswered request holds its address and strobe
   p_req_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack && !srst) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
   // R10: never push into a full FIFO
   p_no_push_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_push |-> !fifo_full);
   // R10: never pop from an empty FIFO
   p_no_pop_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> !fifo_empty);
endmodule

// File: rtl/chain_dma.sv
module chain_dma
   import chain_dma_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int CNT_W    = 16,
   parameter bit ROUND_UP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_addr,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_err,
   output logic              fifo_push,
   output logic [DATA_W-1:0] fifo_wdata,
   input  logic              fifo_full,
   output logic              fifo_pop,
   input  logic [DATA_W-1:0] fifo_rdata,
   input  logic              fifo_empty,
   input  logic              periph_end,
   output logic              irq
);
   logic              soft_rst, start, start_dir, run, busy, fin;
   logic [ADDR_W-1:0] start_ptr;
   logic [3:0]        fin_code;

   chain_dma_regs #(.AW(ADDR_W)) u_regs (
      .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
      .soft_rst, .start, .start_ptr, .start_dir, .run_o(run),
      .fin, .fin_code, .irq
   );

   chain_dma_engine #(.AW(ADDR_W), .DW(DATA_W), .CNT_W(CNT_W), .ROUND_UP(ROUND_UP)) u_eng (
      .clk, .rst_n, .srst(soft_rst), .start, .start_ptr, .start_dir,
      .busy, .fin, .fin_code,
      .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack, .mem_rdata, .mem_err,
      .fifo_push, .fifo_wdata, .fifo_full, .fifo_pop, .fifo_rdata, .fifo_empty,
      .periph_end
   );

   // R3: the engine only works while run is set
   p_busy_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> run);
endmodule

// File: tb/tb_chain_dma.sv
module tb_chain_dma;
   logic        clk = 1'b0, rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0, cfg_rdata;
   logic        mem_req, mem_we, mem_ack = 1'b0, mem_err = 1'b0;
   logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
   logic        fifo_push, fifo_pop, fifo_full, fifo_empty, periph_end = 1'b0, irq;
   logic [31:0] fifo_wdata, fifo_rdata;

   chain_dma dut (.*);

   always #5 clk = ~clk;

   logic [31:0] mem [0:255];
   logic        bw_en = 1'b0;
   logic [7:0]  bw_idx = '0;
   logic [31:0] bw_data = '0;
   logic [31:0] err_addr = 32'hFFFF_FFF0;
   int          req_cnt = 0, rsvd_cnt = 0, pop_idx = 0, src_lim = 0, push_cnt = 0;
   logic [31:0] push_log [0:63];
   logic        full_force = 1'b0;

   always @(posedge clk) begin
      mem_ack <= 1'b0; mem_err <= 1'b0;
      if (bw_en) mem[bw_idx] <= bw_data;
      if (mem_req && !mem_ack) begin
         mem_ack   <= 1'b1;
         mem_err   <= (mem_addr == err_addr);
         mem_rdata <= mem[mem_addr[9:2]];
         req_cnt   <= req_cnt + 1;
         if (mem_we && mem_addr != err_addr) mem[mem_addr[9:2]] <= mem_wdata;
         if (!mem_we && mem_addr < 32'h100 && mem_addr[3:0] == 4'hC) rsvd_cnt <= rsvd_cnt + 1;
      end
      if (fifo_pop) pop_idx <= pop_idx + 1;
      if (fifo_push) begin
         push_log[push_cnt[5:0]] <= fifo_wdata;
         push_cnt <= push_cnt + 1;
      end
   end
   assign fifo_rdata = 32'hA500_0000 + 32'(pop_idx);
   assign fifo_empty = (pop_idx >= src_lim);
   assign fifo_full  = full_force;

   int checks = 0, fails = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk); cfg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk); cfg_addr = a; #1 d = cfg_rdata;
   endtask

   task automatic poke(input logic [31:0] byte_addr, input logic [31:0] d);
      @(negedge clk); bw_en = 1'b1; bw_idx = byte_addr[9:2]; bw_data = d;
      @(negedge clk); bw_en = 1'b0;
   endtask

   task automatic desc(input logic [31:0] at, input logic [31:0] flags,
                       input logic [31:0] bufa, input logic [31:0] nxt);
      poke(at, flags); poke(at + 4, bufa); poke(at + 8, nxt); poke(at + 12, 32'hDEAD_BEEF);
   endtask

   task automatic wait_stop(input string req);
      logic [31:0] v;
      int n = 0;
      do begin rd(3'd4, v); n++; end while (v[7] && n < 3000);
      if (n >= 3000) chk({req, " watchdog"}, 32'd1, 32'd0);
   endtask

   task automatic go(input logic dir);
      wr(3'd3, 32'h0);
      wr(3'd4, {9'b0, dir, 14'b0, 1'b1, 7'b0});
   endtask

   // {dir, count[15:0]} single-descriptor cases, all expected to end with 0xF
   localparam logic [16:0] TV [0:5] = '{
      {1'b0, 16'd16}, {1'b1, 16'd8}, {1'b0, 16'd5},
      {1'b1, 16'd0},  {1'b0, 16'd12}, {1'b1, 16'd3}
   };

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      logic [31:0] v;
      int p0, q0, r0, words;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      for (int a = 0; a < 5; a++) begin
         rd(3'(a), v); chk("R1 reg reset", v, 32'h0);
      end
      chk("R1 irq low", {31'b0, irq}, 32'h0);
      chk("R1 strobes", {29'b0, mem_req, fifo_push, fifo_pop}, 32'h0);

      // R3 enable gating: run write ignored while disabled
      r0 = req_cnt;
      desc(32'h0, 32'hC000_0004, 32'h100, 32'h0);
      go(1'b0);
      repeat (5) @(negedge clk);
      rd(3'd4, v); chk("R3 run stays 0 when disabled", {31'b0, v[7]}, 32'h0);
      chk("R3 no request when disabled", 32'(req_cnt - r0), 32'h0);

      wr(3'd0, 32'h1); wr(3'd1, 32'h1);
      rd(3'd0, v); chk("R2 enable reads back", v, 32'h1);

      // table walk: R4/R5/R6/R7
      foreach (TV[i]) begin
         logic dir; logic [15:0] cnt;
         dir = TV[i][16]; cnt = TV[i][15:0];
         words = (int'(cnt) + 3) / 4;
         desc(32'h0, 32'hC000_0000 | 32'(cnt), 32'h100, 32'h0);
         for (int k = 0; k < 4; k++) poke(32'h100 + 32'(4*k), 32'h1000 + 32'(16*i + k));
         src_lim = 1000; p0 = push_cnt; q0 = pop_idx; r0 = rsvd_cnt;
         go(dir);
         wait_stop("R7");
         rd(3'd4, v); chk("R7 event success", {28'b0, v[3:0]}, 32'hF);
         chk("R12 irq on stop", {31'b0, irq}, 32'h1);
         chk("R4 reserved word unread", 32'(rsvd_cnt - r0), 32'h0);
         if (!dir) begin
            chk("R5 push count", 32'(push_cnt - p0), 32'(words));
            for (int k = 0; k < words; k++)
               chk("R5 push data", push_log[6'(p0 + k)], 32'h1000 + 32'(16*i + k));
         end else begin
            chk("R6 pop count", 32'(pop_idx - q0), 32'(words));
            for (int k = 0; k < words; k++)
               chk("R6 memory data", mem[8'h40 + 8'(k)], 32'hA500_0000 + 32'(q0 + k));
         end
         wr(3'd2, 32'h1);
         chk("R12 W1C clears irq", {31'b0, irq}, 32'h0);
      end

      // R7 chain of three descriptors
      desc(32'h00, 32'h4000_0008, 32'h140, 32'h30);
      desc(32'h30, 32'h4000_0004, 32'h180, 32'h60);
      desc(32'h60, 32'hC000_0004, 32'h1C0, 32'h0);
      poke(32'h140, 32'h11); poke(32'h144, 32'h22); poke(32'h180, 32'h33); poke(32'h1C0, 32'h44);
      p0 = push_cnt;
      go(1'b0); wait_stop("R7 chain");
      rd(3'd4, v); chk("R7 chain event", {28'b0, v[3:0]}, 32'hF);
      chk("R7 chain count", 32'(push_cnt - p0), 32'd4);
      chk("R7 chain w0", push_log[6'(p0)],   32'h11);
      chk("R7 chain w1", push_log[6'(p0+1)], 32'h22);
      chk("R7 chain w2", push_log[6'(p0+2)], 32'h33);
      chk("R7 chain w3", push_log[6'(p0+3)], 32'h44);
      wr(3'd2, 32'h1);

      // R8 bad format bit
      desc(32'h0, 32'h8000_0004, 32'h100, 32'h0);
      p0 = push_cnt; go(1'b0); wait_stop("R8");
      rd(3'd4, v); chk("R8 format event", {28'b0, v[3:0]}, 32'h3);
      chk("R8 nothing moved", 32'(push_cnt - p0), 32'h0);
      wr(3'd2, 32'h1);
      // R8 fetch error
      desc(32'h0, 32'hC000_0004, 32'h100, 32'h0);
      err_addr = 32'h4; go(1'b0); wait_stop("R8");
      rd(3'd4, v); chk("R8 fetch error event", {28'b0, v[3:0]}, 32'h3);
      wr(3'd2, 32'h1);
      // R9 data error
      err_addr = 32'h100; go(1'b0); wait_stop("R9");
      rd(3'd4, v); chk("R9 data error event", {28'b0, v[3:0]}, 32'h4);
      wr(3'd2, 32'h1);
      err_addr = 32'hFFFF_FFF0;

      // R10 underrun and overrun
      src_lim = pop_idx; q0 = pop_idx;
      go(1'b1); wait_stop("R10");
      rd(3'd4, v); chk("R10 underrun event", {28'b0, v[3:0]}, 32'h1);
      chk("R10 no pop when empty", 32'(pop_idx - q0), 32'h0);
      wr(3'd2, 32'h1);
      full_force = 1'b1; p0 = push_cnt;
      go(1'b0); wait_stop("R10");
      rd(3'd4, v); chk("R10 overrun event", {28'b0, v[3:0]}, 32'h2);
      chk("R10 no push when full", 32'(push_cnt - p0), 32'h0);
      full_force = 1'b0;
      wr(3'd2, 32'h1);

      // R11 early end, then ignored when nothing remains
      periph_end = 1'b1;
      desc(32'h0, 32'hC000_0008, 32'h100, 32'h0);
      p0 = push_cnt; go(1'b0); wait_stop("R11");
      rd(3'd4, v); chk("R11 early end event", {28'b0, v[3:0]}, 32'h5);
      chk("R11 no push", 32'(push_cnt - p0), 32'h0);
      wr(3'd2, 32'h1);
      desc(32'h0, 32'hC000_0000, 32'h100, 32'h0);
      go(1'b0); wait_stop("R11");
      rd(3'd4, v); chk("R11 end ignored with zero left", {28'b0, v[3:0]}, 32'hF);
      periph_end = 1'b0;
      wr(3'd2, 32'h1);

      // R12 masking and write-zero
      wr(3'd1, 32'h0);
      go(1'b0); wait_stop("R12");
      chk("R12 masked irq", {31'b0, irq}, 32'h0);
      wr(3'd2, 32'h0);
      rd(3'd2, v); chk("R12 write 0 keeps status", v, 32'h1);
      wr(3'd1, 32'h1);
      chk("R12 unmask raises irq", {31'b0, irq}, 32'h1);
      wr(3'd2, 32'h1);
      rd(3'd2, v); chk("R12 status cleared", v, 32'h0);

      // R13 writes ignored while running
      desc(32'h0, 32'hC000_0040, 32'h100, 32'h0);
      p0 = push_cnt;
      go(1'b0);
      rd(3'd4, v); chk("R13 event zero while running", {28'b0, v[3:0]}, 32'h0);
      wr(3'd4, 32'h0040_000A);
      rd(3'd4, v); chk("R13 run held", {31'b0, v[7]}, 32'h1);
      chk("R13 dir held", {31'b0, v[22]}, 32'h0);
      wait_stop("R13");
      chk("R13 full transfer", 32'(push_cnt - p0), 32'd16);
      wr(3'd2, 32'h1);

      // R2 soft reset
      wr(3'd3, 32'h40);
      wr(3'd0, 32'h0000_0101);
      for (int a = 0; a < 5; a++) begin
         rd(3'(a), v); chk("R2 soft reset value", v, 32'h0);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule